// File: doc/BRIEF.md
# Receive Sample Phase Tuning Sweep Controller

This controller runs the receive-side tuning pass of a card host. After a start pulse it walks a counter through a fixed number of steps. At each step it loads the data timeout with its largest value and asks an external timing sequencer to apply one sample phase in the bus timing mode captured at start. It then asks an external command engine to issue a single tuning command. The pass or fail flag returned with that command is written into a per-phase result mask.

The sweep has more steps (40) than phases (32), so the phase index wraps. The lowest phases are visited a second time, and the later result replaces the earlier one. When the sweep ends, the controller hands the mask to an external best-phase finder. If the finder reports that no phase is usable, tuning stops with a failure. Otherwise the chosen phase is applied once more through the timing sequencer, and the controller reports completion along with that phase.

Each request to the three external agents is held high, with a stable payload, until the agent acknowledges it in the same cycle. That cycle completes the transfer.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: A sweep makes exactly 40 timing-apply transfers, and step i carries phase i modulo 32. Each apply is followed by exactly one tuning command, so 40 commands in total.
- R2: One cycle before every sweep apply request rises, `tmo_load` pulses for one cycle with `tmo_value` all ones. That gives 40 pulses per sweep, and apply k is preceded by k+1 pulses.
- R3: Bit p of `mask` holds the pass flag of the most recent command issued at phase p. For phases 0 to 7, the second visit overrides the first in either direction.
- R4: In the cycle after an accepted start, `mask` is all zeros, `done` and `fail` are low and `busy` is high.
- R5: After the last command, `find_req` rises. If the finder acknowledges without error, one further timing apply carries `find_phase`. After that apply is acknowledged, `done`=1, `fail`=0 and `phase` equals the chosen value.
- R6: If the finder acknowledges with `find_err`=1, `done`=1, `fail`=1 and `phase`=0, and no further timing apply is made.
- R7: A start pulse while `busy` is high is ignored. The running sweep still makes exactly 40 commands and yields the same mask.
- R8: `tmg_mode` equals the `bus_mode` value sampled with the accepted start, for every apply of that run, even if `bus_mode` changes later.
- R9: A request held without acknowledge stays high with a stable phase in the next cycle. At most one of `tmo_load`, `tmg_req`, `cmd_req` and `find_req` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; honoured only when not busy |
| bus_mode | input | MODE_W | Bus timing mode, captured at start |
| tmo_load | output | 1 | Strobe that loads the data timeout |
| tmo_value | output | TMO_W | Timeout value, all ones while `tmo_load` is high |
| tmg_req | output | 1 | Request to the timing sequencer |
| tmg_phase | output | PH_W | Sample phase to apply |
| tmg_mode | output | MODE_W | Timing mode to apply |
| tmg_ack | input | 1 | Timing sequencer acknowledge |
| cmd_req | output | 1 | Request to send one tuning command |
| cmd_ack | input | 1 | Command engine acknowledge |
| cmd_pass | input | 1 | Command result, valid with `cmd_ack` |
| find_req | output | 1 | Request to the best-phase finder (reads `mask`) |
| find_ack | input | 1 | Finder acknowledge |
| find_err | input | 1 | Finder reports no usable phase, valid with `find_ack` |
| find_phase | input | PH_W | Chosen phase, valid with `find_ack` |
| busy | output | 1 | A tuning run is in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Run finished without a usable phase |
| phase | output | PH_W | Chosen phase after success, else 0 |
| mask | output | PHASES | Per-phase pass mask |

## Verification
The handshake assertions assume that each agent raises its acknowledge only while the matching request is high, and only for one cycle. They also assume that `cmd_pass`, `find_err` and `find_phase` are valid in that cycle. The bench responders keep to this: they watch for a pending request at the falling edge, wait a scenario-chosen number of cycles, and raise the acknowledge for exactly one cycle. The mode-stability check relies on `bus_mode` being sampled only at an accepted start. The bench therefore changes `bus_mode` mid-run and fires stray start pulses to show that neither reaches the outputs.

// File: rtl/tune_pkg.sv
// Package: shared state encoding of the tuning sweep controller.
// Assumes: nothing beyond IEEE 1800-2017.
package tune_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TMO   = 3'd1,
        ST_APPLY = 3'd2,
        ST_CMD   = 3'd3,
        ST_FIND  = 3'd4,
        ST_FINAL = 3'd5,
        ST_DONE  = 3'd6
    } tune_state_t;

endpackage

// File: rtl/tune_step_ctr.sv
// Module: step and phase counters of the sweep.
// The step counter runs 0..NUM_STEPS-1. The phase counter wraps at PHASES, so
// the phase always equals step modulo PHASES without a divider.
// Assumes: clr and adv are never high together.
module tune_step_ctr #(
    parameter int NUM_STEPS = 40,
    parameter int PHASES    = 32,
    parameter int STEP_W    = $clog2(NUM_STEPS),
    parameter int PH_W      = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [STEP_W-1:0] step,
    output logic [PH_W-1:0]   phase,
    output logic              last
);

    localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(NUM_STEPS - 1);
    localparam logic [PH_W-1:0]   PHASE_LAST = PH_W'(PHASES - 1);

    // Purpose: clear on start, otherwise advance both counters together.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            step  <= '0;
            phase <= '0;
        end else if (adv) begin
            step  <= step + 1'b1;
            phase <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
        end
    end

    // Purpose: flag the final step of the sweep.
    always_comb last = (step == STEP_LAST);

    assert_phase_tracks_step_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        32'(phase) == (32'(step) % PHASES));

    assert_step_in_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        32'(step) < NUM_STEPS);

endmodule

// File: rtl/tune_pass_mask.sv
// Module: per-phase pass/fail mask. A write replaces one bit, so a later visit
// to a phase overrides the earlier result in either direction.
// Assumes: clr has priority over wr.
module tune_pass_mask #(
    parameter int PHASES = 32,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PH_W-1:0]   idx,
    input  logic              pass,
    output logic [PHASES-1:0] mask
);

    // Purpose: clear the mask on start, otherwise record one result per write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask <= '0;
        end else if (wr) begin
            mask[idx] <= pass;
        end
    end

    assert_clear_empties_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask == '0));

    assert_write_lands_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (mask[$past(idx)] == $past(pass)));

    assert_idle_holds_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clr) |=> $stable(mask));

endmodule

// File: rtl/tune_sweep_ctrl.sv
// Module: receive sample phase tuning sweep controller (top).
// Sequences timeout load, timing apply and tuning command for each sweep step,
// then best-phase search and a final apply of the chosen phase.
// Assumes: each agent raises its ack for one cycle and only while its request
// is high; cmd_pass, find_err and find_phase are valid with the ack.
module tune_sweep_ctrl #(
    parameter int NUM_STEPS = 40,
    parameter int PHASES    = 32,
    parameter int MODE_W    = 4,
    parameter int TMO_W     = 32,
    parameter int PH_W      = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] bus_mode,
    output logic              tmo_load,
    output logic [TMO_W-1:0]  tmo_value,
    output logic              tmg_req,
    output logic [PH_W-1:0]   tmg_phase,
    output logic [MODE_W-1:0] tmg_mode,
    input  logic              tmg_ack,
    output logic              cmd_req,
    input  logic              cmd_ack,
    input  logic              cmd_pass,
    output logic              find_req,
    input  logic              find_ack,
    input  logic              find_err,
    input  logic [PH_W-1:0]   find_phase,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [PH_W-1:0]   phase,
    output logic [PHASES-1:0] mask
);
    import tune_pkg::*;

    localparam int STEP_W = $clog2(NUM_STEPS);

    tune_state_t       state_q;
    logic [MODE_W-1:0] mode_q;
    logic [PH_W-1:0]   sel_q;
    logic              done_q;
    logic              fail_q;
    logic              start_ok;
    logic              step_adv;
    logic              mask_wr;
    logic [STEP_W-1:0] step_cnt;
    logic [PH_W-1:0]   sweep_phase;
    logic              step_last;

    // Purpose: accept start only when no run is active.
    always_comb start_ok = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // Purpose: counter advance and mask write happen on each command ack.
    always_comb begin
        mask_wr  = (state_q == ST_CMD) && cmd_ack;
        step_adv = mask_wr && !step_last;
    end

    tune_step_ctr #(
        .NUM_STEPS (NUM_STEPS),
        .PHASES    (PHASES),
        .STEP_W    (STEP_W),
        .PH_W      (PH_W)
    ) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .adv   (step_adv),
        .step  (step_cnt),
        .phase (sweep_phase),
        .last  (step_last)
    );

    tune_pass_mask #(
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .wr    (mask_wr),
        .idx   (sweep_phase),
        .pass  (cmd_pass),
        .mask  (mask)
    );

    // Purpose: main sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state_q <= ST_TMO;
                        mode_q  <= bus_mode;
                        sel_q   <= '0;
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                    end
                end
                ST_TMO:   state_q <= ST_APPLY;
                ST_APPLY: if (tmg_ack) state_q <= ST_CMD;
                ST_CMD: begin
                    if (cmd_ack) state_q <= step_last ? ST_FIND : ST_TMO;
                end
                ST_FIND: begin
                    if (find_ack) begin
                        if (find_err) begin
                            state_q <= ST_DONE;
                            done_q  <= 1'b1;
                            fail_q  <= 1'b1;
                            sel_q   <= '0;
                        end else begin
                            state_q <= ST_FINAL;
                            sel_q   <= find_phase;
                        end
                    end
                end
                ST_FINAL: begin
                    if (tmg_ack) begin
                        state_q <= ST_DONE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode requests and results from state.
    always_comb begin
        tmo_load  = (state_q == ST_TMO);
        tmo_value = tmo_load ? '1 : '0;
        tmg_req   = (state_q == ST_APPLY) || (state_q == ST_FINAL);
        tmg_phase = (state_q == ST_FINAL) ? sel_q : sweep_phase;
        tmg_mode  = mode_q;
        cmd_req   = (state_q == ST_CMD);
        find_req  = (state_q == ST_FIND);
        busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done      = done_q;
        fail      = fail_q;
        phase     = sel_q;
    end

    assert_tmg_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (tmg_req && !tmg_ack) |=> (tmg_req && $stable(tmg_phase)));

    assert_cmd_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> cmd_req);

    assert_find_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (find_req && !find_ack) |=> find_req);

    assert_single_active_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmo_load, tmg_req, cmd_req, find_req}));

    assert_tmo_then_apply_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        tmo_load |=> tmg_req);

    assert_fail_has_done_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_mode_steady_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(tmg_mode)));

    assert_finish_after_apply_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (tmg_req && tmg_ack && !tmo_load && (state_q == ST_FINAL)) |=> (done && !fail));

endmodule

// File: tb/sim_tune_sweep_ctrl.sv
// Bench: directed scenarios for the tuning sweep controller, one task each.
module sim_tune_sweep_ctrl;

    localparam int NUM_STEPS = 40;
    localparam int PHASES    = 32;
    localparam int MODE_W    = 4;
    localparam int TMO_W     = 32;
    localparam int PH_W      = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [MODE_W-1:0] bus_mode = '0;
    logic              tmo_load;
    logic [TMO_W-1:0]  tmo_value;
    logic              tmg_req;
    logic [PH_W-1:0]   tmg_phase;
    logic [MODE_W-1:0] tmg_mode;
    logic              tmg_ack = 1'b0;
    logic              cmd_req;
    logic              cmd_ack = 1'b0;
    logic              cmd_pass = 1'b0;
    logic              find_req;
    logic              find_ack = 1'b0;
    logic              find_err = 1'b0;
    logic [PH_W-1:0]   find_phase = '0;
    logic              busy;
    logic              done;
    logic              fail;
    logic [PH_W-1:0]   phase;
    logic [PHASES-1:0] mask;

    always #2 clk = ~clk;

    tune_sweep_ctrl #(
        .NUM_STEPS (NUM_STEPS), .PHASES (PHASES), .MODE_W (MODE_W), .TMO_W (TMO_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .bus_mode (bus_mode),
        .tmo_load (tmo_load), .tmo_value (tmo_value),
        .tmg_req (tmg_req), .tmg_phase (tmg_phase), .tmg_mode (tmg_mode), .tmg_ack (tmg_ack),
        .cmd_req (cmd_req), .cmd_ack (cmd_ack), .cmd_pass (cmd_pass),
        .find_req (find_req), .find_ack (find_ack), .find_err (find_err), .find_phase (find_phase),
        .busy (busy), .done (done), .fail (fail), .phase (phase), .mask (mask)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int lat_t = 0, lat_c = 0, lat_f = 0;
    logic [31:0] pat_a = '0, pat_b = '0;
    logic        f_err = 1'b0;
    logic [4:0]  f_ph  = '0;
    int n_vis = 0, n_apply = 0, n_tmo = 0, n_tmo_bad = 0;
    logic [4:0] ap_ph   [0:63];
    logic [3:0] ap_mode [0:63];
    int         ap_tmo  [0:63];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Timing sequencer model.
    initial forever begin
        @(negedge clk);
        if (tmg_req && !tmg_ack) begin
            repeat (lat_t) @(negedge clk);
            tmg_ack = 1'b1;
            @(negedge clk);
            tmg_ack = 1'b0;
        end
    end

    // Command engine model: pass flag from visit order.
    initial forever begin
        @(negedge clk);
        if (cmd_req && !cmd_ack) begin
            repeat (lat_c) @(negedge clk);
            cmd_pass = (n_vis < 32) ? pat_a[n_vis] : pat_b[n_vis - 32];
            n_vis++;
            cmd_ack = 1'b1;
            @(negedge clk);
            cmd_ack = 1'b0;
        end
    end

    // Best-phase finder model.
    initial forever begin
        @(negedge clk);
        if (find_req && !find_ack) begin
            repeat (lat_f) @(negedge clk);
            find_err   = f_err;
            find_phase = f_ph;
            find_ack   = 1'b1;
            @(negedge clk);
            find_ack = 1'b0;
        end
    end

    // Monitor: sampled after the falling edge, when ack and req are settled.
    initial forever begin
        @(negedge clk);
        #1;
        if (tmo_load) begin
            n_tmo++;
            if (tmo_value != '1) n_tmo_bad++;
        end
        if (tmg_req && tmg_ack && n_apply < 64) begin
            ap_ph[n_apply]   = tmg_phase;
            ap_mode[n_apply] = tmg_mode;
            ap_tmo[n_apply]  = n_tmo;
            n_apply++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    function automatic logic [31:0] exp_mask(input logic [31:0] a, input logic [31:0] b);
        return {a[31:8], b[7:0]};
    endfunction

    task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic e,
                          input logic [4:0] p, input logic [3:0] m);
        pat_a = a; pat_b = b; f_err = e; f_ph = p;
        n_vis = 0; n_apply = 0; n_tmo = 0; n_tmo_bad = 0;
        bus_mode = m;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        #1;
    endtask

    task automatic check_sweep(input int exp_applies, input logic [3:0] m);
        int bad_ph = 0, bad_tmo = 0, bad_md = 0;
        for (int i = 0; i < 40; i++) begin
            if (ap_ph[i] != 5'(i % 32)) bad_ph++;
            if (ap_tmo[i] != i + 1) bad_tmo++;
        end
        for (int i = 0; i < exp_applies; i++) if (ap_mode[i] != m) bad_md++;
        check(n_apply == exp_applies, "R1 apply count", 64'(n_apply), 64'(exp_applies));
        check(bad_ph == 0, "R1 phase order", 64'(bad_ph), 0);
        check(n_vis == NUM_STEPS, "R1 command count", 64'(n_vis), 64'(NUM_STEPS));
        check(bad_tmo == 0 && n_tmo == 40 && n_tmo_bad == 0, "R2 timeout before apply",
              64'(n_tmo), 40);
        check(bad_md == 0, "R8 mode on applies", 64'(bad_md), 0);
    endtask

    task automatic t_reset();
        #1;
        check(!done && !fail && !busy, "R4 reset flags", {61'd0, done, fail, busy}, 0);
        check(mask == '0 && phase == '0, "R4 reset mask", 64'(mask), 0);
        check(!tmg_req && !cmd_req && !find_req && !tmo_load, "R9 reset requests",
              {60'd0, tmg_req, cmd_req, find_req, tmo_load}, 0);
    endtask

    task automatic t_basic();
        lat_t = 0; lat_c = 1; lat_f = 0;
        launch(32'hF00F_FF00, 32'h0000_00A5, 1'b0, 5'd13, 4'd3);
        wait_done();
        check_sweep(41, 4'd3);
        check(mask == exp_mask(pat_a, pat_b), "R3 mask basic", 64'(mask),
              64'(exp_mask(pat_a, pat_b)));
        check(ap_ph[40] == 5'd13, "R5 final apply phase", 64'(ap_ph[40]), 13);
        check(done && !fail && phase == 5'd13, "R5 success result", 64'(phase), 13);
    endtask

    task automatic t_override();
        lat_t = 2; lat_c = 0; lat_f = 3;
        launch(32'h8000_00F0, 32'h0000_000F, 1'b0, 5'd31, 4'd9);
        wait_done();
        check_sweep(41, 4'd9);
        check(mask[7:0] == 8'h0F, "R3 second visit overrides", 64'(mask[7:0]), 8'h0F);
        check(mask == 32'h8000_000F, "R3 mask override", 64'(mask), 32'h8000_000F);
        check(done && !fail && phase == 5'd31, "R5 phase at top", 64'(phase), 31);
    endtask

    task automatic t_all_bad();
        lat_t = 1; lat_c = 2; lat_f = 1;
        launch(32'h0, 32'h0, 1'b1, 5'd7, 4'd5);
        wait_done();
        repeat (5) @(negedge clk);
        #1;
        check(n_apply == 40, "R6 no final apply", 64'(n_apply), 40);
        check(done && fail && phase == '0, "R6 failure result",
              {57'd0, done, fail, phase}, {57'd0, 1'b1, 1'b1, 5'd0});
        check(mask == '0, "R3 all-fail mask", 64'(mask), 0);
    endtask

    task automatic t_busy_start();
        lat_t = 0; lat_c = 0; lat_f = 0;
        launch(32'h1234_5678, 32'h0000_0099, 1'b0, 5'd2, 4'd6);
        repeat (30) @(negedge clk);
        bus_mode = 4'd12;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check_sweep(41, 4'd6);
        check(mask == exp_mask(pat_a, pat_b), "R7 mask after stray start", 64'(mask),
              64'(exp_mask(pat_a, pat_b)));
        check(done && !fail && phase == 5'd2, "R7 run completes", 64'(phase), 2);
    endtask

    task automatic t_restart();
        lat_t = 0; lat_c = 0; lat_f = 0;
        launch(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd16, 4'd1);
        wait_done();
        check(mask == 32'hFFFF_FFFF, "R3 all-pass mask", 64'(mask), 32'hFFFF_FFFF);
        launch(32'h0000_0001, 32'h0, 1'b0, 5'd0, 4'd2);
        #1;
        check(mask == '0 && !done && !fail && busy, "R4 start clears",
              {28'd0, mask, 1'b0, done, fail, busy}, {60'd0, 4'b0001});
        wait_done();
        check(mask == 32'h0, "R3 low phase overwritten to fail", 64'(mask), 0);
        check(done && !fail && phase == 5'd0, "R5 restart result", 64'(phase), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_override();
        t_all_bad();
        t_busy_start();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule